// File: doc/BRIEF.md
# Three-Channel Match and Overflow Timer

This peripheral holds three independent 32-bit counters behind a simple word-addressed register port. Each channel has a live count, a reload value and two compare values. A shared control word turns each channel on, picks whether it advances on every system clock or only on cycles where an external tick strobe is high, and picks its direction. When a channel wraps, it takes its next value from its reload register. This gives a programmable period without software touching the count.

Compare hits and wraps of all channels are recorded as sticky flags in one status word. A mask word and the per-channel interrupt-enable bits select which flags drive the single interrupt line. Software clears flags by writing zeros. A hardware event arriving in the same cycle as the clear keeps its flag set.

Top module: `tri_match_timer`

## Requirements
- R1: Registers use word index `addr` (byte offset divided by 4). Channel k (0..2) has count at 4k, reload at 4k+1, compare A at 4k+2 and compare B at 4k+3. Control is at 12, status at 13 and mask at 14. Control keeps only its low 12 bits and mask only its low 9 bits. Reads of index 15 return zero, and writes to index 15 have no effect.
- R2: After reset, every register reads zero except mask, which reads 0x1FF, and `irq` is low.
- R3: A channel with control bit 3k set (run) and bit 9+k set (up) advances its count by one on each active tick.
- R4: An up-counting channel at 0xFFFFFFFF loads its reload value on the next active tick and sets status bit 3k+2. A reload value of 0xFFFFFFFF-(P-1) therefore gives a wrap every P ticks.
- R5: With bit 9+k clear, a channel counts down. From zero it loads its reload value on the next active tick and sets status bit 3k+2.
- R6: Clearing run bit 3k freezes the count, and setting it again resumes counting from the frozen value.
- R7: With control bit 3k+1 clear, a tick happens on every clock. With it set, a tick happens only on cycles where `tick_i` is high.
- R8: A write to a count register takes effect at that clock edge and overrides counting in that cycle.
- R9: While a channel runs, a count equal to compare A sets status bit 3k, and a count equal to compare B sets status bit 3k+1. The flag is visible one cycle after the equality.
- R10: Status bits are sticky. A status write clears the bits written as 0 and keeps the bits written as 1. An event in the same cycle wins over the clear.
- R11: `irq` is high exactly when some status bit is set, its mask bit is 0, and its channel's interrupt-enable bit (control bit 3k+2) is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Tick strobe, synchronous to clk |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word index |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The bench checks the wrap boundaries in both directions. A design that compared against the wrong end value or skipped the reload would show a wrong count or a missing overflow flag exactly one tick after the end value. It times the compare flag to the cycle, so a design that registered the hit twice, or compared while stopped, would show the flag late or early. It checks a clear racing a live compare hit, where a design that gave the clear priority would drop the flag. It also checks the interaction of mask and interrupt enable, where gating on only one of them would raise `irq` falsely.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned EVT_PER_CH = 3;
  localparam int unsigned EVT_CMP_A  = 0;
  localparam int unsigned EVT_CMP_B  = 1;
  localparam int unsigned EVT_WRAP   = 2;

  typedef enum logic [1:0] {
    SLOT_COUNT  = 2'd0,
    SLOT_RELOAD = 2'd1,
    SLOT_CMP_A  = 2'd2,
    SLOT_CMP_B  = 2'd3
  } ch_slot_e;

  localparam logic [3:0] IDX_CTRL   = 4'd12;
  localparam logic [3:0] IDX_STATUS = 4'd13;
  localparam logic [3:0] IDX_MASK   = 4'd14;
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic          running,
  input  logic          up,
  input  logic          wr_cnt,
  input  logic          wr_reload,
  input  logic          wr_cmp_a,
  input  logic          wr_cmp_b,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] cnt_o,
  output logic [DW-1:0] reload_o,
  output logic [DW-1:0] cmp_a_o,
  output logic [DW-1:0] cmp_b_o,
  output logic [2:0]    evt_o
);
  localparam logic [DW-1:0] TOP = '1;
  localparam logic [DW-1:0] BOT = '0;

  logic [DW-1:0] cnt_q, cnt_d, reload_q, reload_d, cmp_a_q, cmp_a_d, cmp_b_q, cmp_b_d;
  logic          at_end, wrap;

  always_comb begin
    at_end   = up ? (cnt_q == TOP) : (cnt_q == BOT);
    wrap     = 1'b0;
    cnt_d    = cnt_q;
    if (wr_cnt) begin
      cnt_d = wdata;
    end else if (step) begin
      if (at_end) begin
        cnt_d = reload_q;
        wrap  = 1'b1;
      end else if (up) begin
        cnt_d = cnt_q + 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
    reload_d = wr_reload ? wdata : reload_q;
    cmp_a_d  = wr_cmp_a  ? wdata : cmp_a_q;
    cmp_b_d  = wr_cmp_b  ? wdata : cmp_b_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
      cmp_a_q  <= '0;
      cmp_b_q  <= '0;
    end else begin
      cnt_q    <= cnt_d;
      reload_q <= reload_d;
      cmp_a_q  <= cmp_a_d;
      cmp_b_q  <= cmp_b_d;
    end
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
  assign cmp_a_o  = cmp_a_q;
  assign cmp_b_o  = cmp_b_q;
  assign evt_o[tmr_pkg::EVT_CMP_A] = running && (cnt_q == cmp_a_q);
  assign evt_o[tmr_pkg::EVT_CMP_B] = running && (cnt_q == cmp_b_q);
  assign evt_o[tmr_pkg::EVT_WRAP]  = wrap;
endmodule

// File: rtl/tmr_irq_ctrl.sv
module tmr_irq_ctrl #(
  parameter int unsigned NCH = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [3*NCH-1:0]     evt,
  input  logic                 wr_status,
  input  logic                 wr_mask,
  input  logic [3*NCH-1:0]     wbits,
  input  logic [NCH-1:0]       ien,
  output logic [3*NCH-1:0]     status_o,
  output logic [3*NCH-1:0]     mask_o,
  output logic                 irq_o
);
  localparam int unsigned NEV = tmr_pkg::EVT_PER_CH * NCH;

  logic [NEV-1:0] status_q, status_d, mask_q, mask_d, ien_vec;

  for (genvar k = 0; k < NCH; k++) begin : g_ien
    assign ien_vec[3*k +: 3] = {3{ien[k]}};
  end

  always_comb begin
    status_d = evt | (wr_status ? (status_q & wbits) : status_q);
    mask_d   = wr_mask ? wbits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q & ien_vec);
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer #(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en,
  input  logic [3:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  import tmr_pkg::*;

  localparam int unsigned NEV   = EVT_PER_CH * NCH;
  localparam int unsigned CTRLW = 4 * NCH;
  localparam logic [3:0]  CH_WORDS = 4'(4 * NCH);

  logic [1:0]        rst_sync_q;
  logic              rst_n_i;
  logic [CTRLW-1:0]  ctrl_q, ctrl_d;
  logic [NCH*DW-1:0] cnt_flat, load_flat, cmpa_flat, cmpb_flat;
  logic [NEV-1:0]    evt_w, status_w, mask_w;
  logic [NCH-1:0]    ien_w;
  logic              in_ch;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  assign in_ch  = (addr < CH_WORDS);
  assign ctrl_d = (wr_en && addr == IDX_CTRL) ? wdata[CTRLW-1:0] : ctrl_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) ctrl_q <= '0;
    else          ctrl_q <= ctrl_d;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic run, sel, up, step, hit;
    assign run  = ctrl_q[3*k];
    assign sel  = ctrl_q[3*k+1];
    assign up   = ctrl_q[3*NCH+k];
    assign step = run && (sel ? tick_i : 1'b1);
    assign hit  = wr_en && in_ch && (addr[3:2] == 2'(k));
    assign ien_w[k] = ctrl_q[3*k+2];

    tmr_channel #(.DW(DW)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n_i),
      .step      (step),
      .running   (run),
      .up        (up),
      .wr_cnt    (hit && addr[1:0] == SLOT_COUNT),
      .wr_reload (hit && addr[1:0] == SLOT_RELOAD),
      .wr_cmp_a  (hit && addr[1:0] == SLOT_CMP_A),
      .wr_cmp_b  (hit && addr[1:0] == SLOT_CMP_B),
      .wdata     (wdata),
      .cnt_o     (cnt_flat[k*DW +: DW]),
      .reload_o  (load_flat[k*DW +: DW]),
      .cmp_a_o   (cmpa_flat[k*DW +: DW]),
      .cmp_b_o   (cmpb_flat[k*DW +: DW]),
      .evt_o     (evt_w[3*k +: 3])
    );
  end

  tmr_irq_ctrl #(.NCH(NCH)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .evt       (evt_w),
    .wr_status (wr_en && addr == IDX_STATUS),
    .wr_mask   (wr_en && addr == IDX_MASK),
    .wbits     (wdata[NEV-1:0]),
    .ien       (ien_w),
    .status_o  (status_w),
    .mask_o    (mask_w),
    .irq_o     (irq)
  );

  always_comb begin
    rdata = '0;
    if (in_ch) begin
      case (addr[1:0])
        SLOT_COUNT:  rdata = cnt_flat[addr[3:2]*DW +: DW];
        SLOT_RELOAD: rdata = load_flat[addr[3:2]*DW +: DW];
        SLOT_CMP_A:  rdata = cmpa_flat[addr[3:2]*DW +: DW];
        default:     rdata = cmpb_flat[addr[3:2]*DW +: DW];
      endcase
    end else begin
      case (addr)
        IDX_CTRL:   rdata = {{(DW-CTRLW){1'b0}}, ctrl_q};
        IDX_STATUS: rdata = {{(DW-NEV){1'b0}}, status_w};
        IDX_MASK:   rdata = {{(DW-NEV){1'b0}}, mask_w};
        default:    rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int unsigned NCH = 3,
  parameter int unsigned DW  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [3:0]        addr,
  input logic [DW-1:0]     wdata,
  input logic              tick,
  input logic              irq,
  input logic [4*NCH-1:0]  ctrl,
  input logic [3*NCH-1:0]  status,
  input logic [3*NCH-1:0]  mask,
  input logic [NCH*DW-1:0] cnt,
  input logic [NCH*DW-1:0] load
);
  localparam logic [DW-1:0] TOP = '1;

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status & ~mask) != '0));

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 4'd13) |=> ((status & $past(status)) == $past(status)));

  // R1
  mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd14) |=> (mask == $past(wdata[3*NCH-1:0])));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == 4'(4*k));

    // R6
    frozen_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl[3*k] && !cnt_wr) |=> $stable(cnt[k*DW +: DW]));

    // R7
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[3*k+1] && !tick && !cnt_wr) |=> $stable(cnt[k*DW +: DW]));

    // R4
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl[3*k] && !ctrl[3*k+1] && ctrl[3*NCH+k] && !cnt_wr &&
       cnt[k*DW +: DW] == TOP)
      |=> (status[3*k+2] && cnt[k*DW +: DW] == $past(load[k*DW +: DW])));
  end
endmodule

bind tri_match_timer tmr_checker #(.NCH(NCH), .DW(DW)) u_tmr_chk (
  .clk    (clk),
  .rst_n  (rst_n_i),
  .wr_en  (wr_en),
  .addr   (addr),
  .wdata  (wdata),
  .tick   (tick_i),
  .irq    (irq),
  .ctrl   (ctrl_q),
  .status (status_w),
  .mask   (mask_w),
  .cnt    (cnt_flat),
  .load   (load_flat)
);

// File: tb/tri_match_timer_bench.sv
module tri_match_timer_bench;
  logic        clk, rst_n, tick_i, wr_en, irq;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  tri_match_timer u_tri_match_timer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [3:0]  a;
    logic [31:0] w;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  32'h0000_0100, 32'h0000_0100},
    '{4'd2,  32'h1111_0000, 32'h1111_0000},
    '{4'd3,  32'h2222_0000, 32'h2222_0000},
    '{4'd4,  32'h0000_0003, 32'h0000_0003},
    '{4'd6,  32'h3333_0000, 32'h3333_0000},
    '{4'd7,  32'h4444_0000, 32'h4444_0000},
    '{4'd9,  32'h0000_0009, 32'h0000_0009},
    '{4'd10, 32'h0000_0040, 32'h0000_0040},
    '{4'd11, 32'h5555_0000, 32'h5555_0000},
    '{4'd12, 32'hFFFF_FE00, 32'h0000_0E00},
    '{4'd15, 32'hDEAD_BEEF, 32'h0000_0000},
    '{4'd14, 32'hFFFF_FFFF, 32'h0000_01FF},
    '{4'd13, 32'h0000_01FF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] w);
    wr_en = 1'b1; addr = a; wdata = w;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    rst_n = 1'b0; tick_i = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edges(3);

    // R2 reset state
    rd(4'd12, v); chk("R2 ctrl", v, 32'h0);
    rd(4'd14, v); chk("R2 mask", v, 32'h1FF);
    rd(4'd13, v); chk("R2 status", v, 32'h0);
    rd(4'd0,  v); chk("R2 count", v, 32'h0);
    chk("R2 irq", {31'b0, irq}, 32'h0);

    // R1 register map table (last vector also covers R10: ones never set)
    for (int i = 0; i < NV; i++) begin
      wr(VECS[i].a, VECS[i].w);
      rd(VECS[i].a, v);
      chk("R1 map", v, VECS[i].exp);
    end

    // R3 up count, R8 direct write
    wr(4'd0, 32'd10);
    wr(4'd12, 32'h201);
    edges(5);
    rd(4'd0, v); chk("R3 up count", v, 32'd15);
    wr(4'd0, 32'd50);
    rd(4'd0, v); chk("R8 write wins", v, 32'd50);
    edges(1);
    rd(4'd0, v); chk("R8 resume", v, 32'd51);

    // R6 freeze and resume
    wr(4'd12, 32'h200);
    rd(4'd0, v); chk("R6 freeze value", v, 32'd52);
    edges(5);
    rd(4'd0, v2); chk("R6 frozen", v2, 32'd52);
    wr(4'd12, 32'h201);
    edges(3);
    rd(4'd0, v); chk("R6 resumed", v, 32'd55);

    // R4 up wrap with reload
    wr(4'd12, 32'h200);
    wr(4'd0, 32'hFFFF_FFFE);
    wr(4'd1, 32'h100);
    wr(4'd13, 32'h0);
    wr(4'd12, 32'h201);
    edges(1);
    rd(4'd0, v); chk("R4 at top", v, 32'hFFFF_FFFF);
    rd(4'd13, v); chk("R4 no wrap yet", v & 32'h4, 32'h0);
    edges(1);
    rd(4'd0, v); chk("R4 reload", v, 32'h100);
    rd(4'd13, v); chk("R4 wrap flag", v & 32'h4, 32'h4);

    // R4 period of 4 ticks
    wr(4'd12, 32'h200);
    wr(4'd1, 32'hFFFF_FFFC);
    wr(4'd0, 32'hFFFF_FFFC);
    wr(4'd13, 32'h0);
    wr(4'd12, 32'h201);
    edges(3);
    rd(4'd13, v); chk("R4 period early", v & 32'h4, 32'h0);
    edges(1);
    rd(4'd0, v); chk("R4 period reload", v, 32'hFFFF_FFFC);
    rd(4'd13, v); chk("R4 period flag", v & 32'h4, 32'h4);
    wr(4'd13, 32'h0);
    edges(3);
    rd(4'd0, v); chk("R4 second period", v, 32'hFFFF_FFFC);
    rd(4'd13, v); chk("R4 second flag", v & 32'h4, 32'h4);
    wr(4'd12, 32'h0);

    // R5 down count on channel 1
    wr(4'd4, 32'd2);
    wr(4'd5, 32'd7);
    wr(4'd13, 32'h0);
    wr(4'd12, 32'h008);
    edges(2);
    rd(4'd4, v); chk("R5 at zero", v, 32'd0);
    rd(4'd13, v); chk("R5 no wrap yet", v & 32'h20, 32'h0);
    edges(1);
    rd(4'd4, v); chk("R5 reload", v, 32'd7);
    rd(4'd13, v); chk("R5 wrap flag", v & 32'h20, 32'h20);
    wr(4'd12, 32'h0);

    // R7 tick strobe on channel 2
    wr(4'd8, 32'd0);
    wr(4'd12, 32'h8C0);
    edges(5);
    rd(4'd8, v); chk("R7 no tick", v, 32'd0);
    tick_i = 1'b1;
    edges(3);
    tick_i = 1'b0;
    rd(4'd8, v); chk("R7 three ticks", v, 32'd3);
    wr(4'd12, 32'h0);

    // R9 compare timing on channel 0
    wr(4'd0, 32'd100);
    wr(4'd2, 32'd103);
    wr(4'd3, 32'd105);
    wr(4'd13, 32'h0);
    wr(4'd12, 32'h201);
    edges(3);
    rd(4'd13, v); chk("R9 cmpA not yet", v & 32'h1, 32'h0);
    edges(1);
    rd(4'd13, v); chk("R9 cmpA flag", v & 32'h3, 32'h1);
    edges(2);
    rd(4'd13, v); chk("R9 cmpB flag", v & 32'h3, 32'h3);
    wr(4'd12, 32'h0);

    // R10 write-zero clear, write-one keep
    wr(4'd13, 32'h1FE);
    rd(4'd13, v); chk("R10 partial clear", v, 32'h002);

    // R10 set wins over clear: channel 2 held on compare A
    wr(4'd8, 32'h40);
    wr(4'd12, 32'h0C0);
    edges(1);
    wr(4'd13, 32'h0);
    rd(4'd13, v); chk("R10 set wins", v, 32'h040);

    // R11 mask and enable gating
    chk("R11 masked", {31'b0, irq}, 32'h0);
    wr(4'd14, 32'h1BF);
    chk("R11 no enable", {31'b0, irq}, 32'h0);
    wr(4'd12, 32'h1C0);
    chk("R11 raised", {31'b0, irq}, 32'h1);
    wr(4'd14, 32'h1FF);
    chk("R11 remasked", {31'b0, irq}, 32'h0);
    wr(4'd14, 32'h1BF);
    wr(4'd12, 32'h100);
    chk("R11 sticky source", {31'b0, irq}, 32'h1);
    wr(4'd13, 32'h0);
    chk("R11 cleared", {31'b0, irq}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule